// File: doc/BRIEF.md
# Mode-Selectable Divide-by-N Down Counter

This block divides its clock by a programmed integer N and produces a one-clock-wide pulse once every N clocks. The count is held in three parts. A fast first section has a run-time modulus M of 2, 4, 5, 8 or 10. Three cascaded decimal-weighted digits follow it. A small last section is built from the low jam bits that the first section does not use. Each time the first section wraps, the combined value in the digits and the last section goes down by one. When the whole count reaches its terminal state, the counter reloads from the jam word and the output pulses in the same clock.

A three-bit mode code selects the modulus, or holds the counter in master preset. In master preset every stage loads from the jam word and counting stops. A latch-enable input can hold the output high after a pulse. Typical uses are frequency synthesis, fixed or programmable division, and long time-out timers.

Top module: `divn_counter`

## Requirements
- R1: With jam word J and a counting mode of modulus M, N = M*(1000*L + 100*D3 + 10*D2 + D1) + F. D1, D2 and D3 are J[7:4], J[11:8] and J[15:12]. F is the low f bits of J[3:0] and L is J[3:f]. divOut is then high for exactly one clock out of every N (N >= 3, latchEn low).
- R2: modeSel codes 3'b100, 3'b101, 3'b110, 3'b111 and 3'b001 select M = 2, 4, 8, 10 and 5. The matching first-section widths f are 1, 2, 3, 4 and 3 bits. The last section L takes the remaining bits of J[3:0], so it is empty when M = 10.
- R3: Each digit also accepts preset values 10 to 15 and keeps its place value, so N follows the R1 formula beyond the plain decimal range.
- R4: The codes 3'b000, 3'b010 and 3'b011 are master preset. All stages load from jam, no count advances, and no new pulse starts after the second preset clock. After switching to a counting mode, the first pulse goes high after the Nth counting clock.
- R5: While counting, the terminal clock reloads the jam value, so successive pulses stay exactly N clocks apart.
- R6: If master preset starts when the pulse is due at the first or second following clock, that pulse still appears on time. If the pulse is three or more clocks away, it is dropped.
- R7: With latchEn high, divOut stays high after a pulse until latchEn is sampled low. It then falls at that clock.
- R8: While rstN is low, divOut is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rstN | input | 1 | Asynchronous active-low reset |
| jam | input | 16 | Preset word: first/last bits in [3:0], three digits above |
| modeSel | input | 3 | Modulus or master-preset code |
| latchEn | input | 1 | Hold divOut high after a pulse |
| divOut | output | 1 | Divided pulse output |

## Verification
Every mode is run with its own jam word. Each word is chosen so that a wrong first-section width, a wrong modulus or a wrong last-section split gives a different period. A digit preset above nine checks the extended range. A four-digit word such as 1234 forces borrows to ripple through all three digits. The smallest legal N shows that the reload leaves no gap between periods. Master preset is entered one, two and three clocks before a due pulse, which separates the keep-the-pulse cases from the drop case. The latch test tells a held output apart from a re-triggered one.

// File: rtl/divn_pkg.sv
package divn_pkg;
  localparam int MOD_W = 4;

  typedef struct packed {
    logic             preset;
    logic [MOD_W-1:0] modulus;
    logic [2:0]       firstW;
  } modeCfg_t;

  typedef struct packed {
    logic load;
    logic step;
  } dpCtrl_t;

  typedef struct packed {
    logic atOne;
    logic atTwo;
  } dpStat_t;

  function automatic modeCfg_t decodeMode(input logic [2:0] code);
    modeCfg_t c;
    c.preset  = 1'b0;
    c.modulus = 4'd10;
    c.firstW  = 3'd4;
    case (code)
      3'b100: begin c.modulus = 4'd2;  c.firstW = 3'd1; end
      3'b101: begin c.modulus = 4'd4;  c.firstW = 3'd2; end
      3'b110: begin c.modulus = 4'd8;  c.firstW = 3'd3; end
      3'b111: begin c.modulus = 4'd10; c.firstW = 3'd4; end
      3'b001: begin c.modulus = 4'd5;  c.firstW = 3'd3; end
      default: c.preset = 1'b1;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/divn_datapath.sv
module divn_datapath
  import divn_pkg::*;
#(
  parameter int FIRST_W     = 4,
  parameter int DIGIT_W     = 4,
  parameter int NUM_DECADES = 3,
  localparam int JAM_W      = FIRST_W + NUM_DECADES * DIGIT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [JAM_W-1:0] jam,
  input  modeCfg_t         cfg,
  input  dpCtrl_t          ctrl,
  output dpStat_t          stat
);
  // Low nibble is stored raw; the mode splits it into first/last on read.
  logic [FIRST_W-1:0] lowQ, lowNext;
  logic [FIRST_W-1:0] firstMask, lastMask;
  logic [FIRST_W-1:0] firstVal, lastVal, firstNext, lastNext;
  logic               firstZero;

  logic [NUM_DECADES-1:0][DIGIT_W-1:0] digitQ, digitNext, jamDigits;
  logic [NUM_DECADES-1:0]              digitZero;
  logic [NUM_DECADES:0]                borrow;

  assign firstMask = ~({FIRST_W{1'b1}} << cfg.firstW);
  assign lastMask  = {FIRST_W{1'b1}} >> cfg.firstW;
  assign firstVal  = lowQ & firstMask;
  assign lastVal   = lowQ >> cfg.firstW;
  assign firstZero = (firstVal == '0);
  assign firstNext = firstZero ? FIRST_W'(cfg.modulus - 1'b1) : firstVal - 1'b1;
  assign borrow[0] = firstZero;

  for (genvar i = 0; i < NUM_DECADES; i++) begin : g_decade
    assign jamDigits[i]  = jam[FIRST_W + i*DIGIT_W +: DIGIT_W];
    assign digitZero[i]  = (digitQ[i] == '0);
    assign borrow[i+1]   = borrow[i] & digitZero[i];
    assign digitNext[i]  = !borrow[i] ? digitQ[i]
                         : (digitZero[i] ? DIGIT_W'(9) : digitQ[i] - 1'b1);
  end

  assign lastNext = borrow[NUM_DECADES] ? ((lastVal - 1'b1) & lastMask) : lastVal;
  assign lowNext  = (lastNext << cfg.firstW) | firstNext;

  logic upperZero, upperIsOne;
  assign upperZero  = (&digitZero) && (lastVal == '0);
  assign upperIsOne = (lastVal == '0) && (digitQ[0] == DIGIT_W'(1))
                   && (&(digitZero | NUM_DECADES'(1)));

  assign stat.atOne = upperZero && (firstVal == FIRST_W'(1));
  assign stat.atTwo = (upperZero && (firstVal == FIRST_W'(2)))
                   || ((cfg.modulus == MOD_W'(2)) && firstZero && upperIsOne);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowQ   <= '0;
      digitQ <= '0;
    end else if (ctrl.load) begin
      lowQ   <= jam[FIRST_W-1:0];
      digitQ <= jamDigits;
    end else if (ctrl.step) begin
      lowQ   <= lowNext;
      digitQ <= digitNext;
    end
  end
endmodule

// File: rtl/divn_control.sv
module divn_control
  import divn_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic [2:0] modeSel,
  input  logic      latchEn,
  input  dpStat_t   stat,
  output modeCfg_t  effCfg,
  output dpCtrl_t   ctrl,
  output logic      divOut
);
  modeCfg_t curCfg, heldCfgQ;
  logic     presetQ, dueQ, outQ, entry, fire;

  assign curCfg = decodeMode(modeSel);
  // During preset the count is still read with the last counting split.
  assign effCfg = curCfg.preset ? heldCfgQ : curCfg;
  assign entry  = curCfg.preset && !presetQ;

  always_comb begin
    if (curCfg.preset) fire = entry ? stat.atOne : dueQ;
    else               fire = stat.atOne;
  end

  assign ctrl.load = curCfg.preset || stat.atOne;
  assign ctrl.step = !ctrl.load;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldCfgQ <= decodeMode(3'b111);
      presetQ  <= 1'b0;
      dueQ     <= 1'b0;
      outQ     <= 1'b0;
    end else begin
      if (!curCfg.preset) heldCfgQ <= curCfg;
      presetQ <= curCfg.preset;
      dueQ    <= curCfg.preset && entry && stat.atTwo;
      outQ    <= fire || (latchEn && outQ);
    end
  end

  assign divOut = outQ;
endmodule

// File: rtl/divn_counter.sv
module divn_counter
  import divn_pkg::*;
#(
  parameter int FIRST_W     = 4,
  parameter int DIGIT_W     = 4,
  parameter int NUM_DECADES = 3,
  localparam int JAM_W      = FIRST_W + NUM_DECADES * DIGIT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [JAM_W-1:0] jam,
  input  logic [2:0]       modeSel,
  input  logic             latchEn,
  output logic             divOut
);
  modeCfg_t effCfg;
  dpCtrl_t  ctrl;
  dpStat_t  stat;

  divn_control u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .latchEn(latchEn),
    .stat(stat), .effCfg(effCfg), .ctrl(ctrl), .divOut(divOut)
  );

  divn_datapath #(
    .FIRST_W(FIRST_W), .DIGIT_W(DIGIT_W), .NUM_DECADES(NUM_DECADES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .jam(jam), .cfg(effCfg), .ctrl(ctrl), .stat(stat)
  );
endmodule

// File: rtl/divn_checker.sv
module divn_checker
  import divn_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [2:0] modeSel,
  input logic       latchEn,
  input logic       divOut
);
  logic presetIn;
  assign presetIn = decodeMode(modeSel).preset;

  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    (divOut && !latchEn && !$past(latchEn)) |=> !divOut);

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (divOut && latchEn) |=> divOut);

  p_preset_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(presetIn, 1) && $past(presetIn, 2) && $past(presetIn, 3)
     && !$past(latchEn)) |-> !divOut);

  p_known_out_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(divOut));
endmodule

bind divn_counter divn_checker u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .latchEn(latchEn), .divOut(divOut)
);

// File: tb/divn_counter_tb.sv
`timescale 1ns/1ps
module divn_counter_tb;
  logic        clk = 1'b0, rstN = 1'b0;
  logic [15:0] jam = 16'h0;
  logic [2:0]  modeSel = 3'b000;
  logic        latchEn = 1'b0;
  logic        divOut;

  divn_counter u_dut (.clk(clk), .rstN(rstN), .jam(jam), .modeSel(modeSel),
                      .latchEn(latchEn), .divOut(divOut));

  always #2.5 clk = ~clk;

  int    checks = 0, fails = 0;
  string curReq = "R8";
  bit    cmpEn = 0;

  int          mdlCnt = 0;
  bit          mdlOut = 0, mdlPrevPre = 0, mdlDue = 0, mdlLoaded = 0;
  logic [15:0] mdlJam = 16'h0;
  int          cycleNo = 0, riseCount = 0, riseCycle = 0;
  bit          prevOut = 0;

  function automatic bit isPreset(input logic [2:0] m);
    return !(m == 3'b100 || m == 3'b101 || m == 3'b110 || m == 3'b111 || m == 3'b001);
  endfunction

  function automatic int jamValue(input logic [15:0] j, input logic [2:0] m);
    int md, fw, f, l;
    case (m)
      3'b100: begin md = 2; fw = 1; end
      3'b101: begin md = 4; fw = 2; end
      3'b110: begin md = 8; fw = 3; end
      3'b001: begin md = 5; fw = 3; end
      default: begin md = 10; fw = 4; end
    endcase
    f = int'(j[3:0]) % (1 << fw);
    l = int'(j[3:0]) / (1 << fw);
    return md * (1000*l + 100*int'(j[15:12]) + 10*int'(j[11:8]) + int'(j[7:4])) + f;
  endfunction

  // Behavioural reference: one integer remaining-count.
  always @(posedge clk) begin
    bit fire, pre;
    cycleNo++;
    if (!rstN) begin
      mdlCnt = 0; mdlOut = 0; mdlPrevPre = 0; mdlDue = 0; mdlLoaded = 0;
    end else begin
      fire = 0;
      pre  = isPreset(modeSel);
      if (pre) begin
        if (!mdlPrevPre) begin fire = (mdlCnt == 1); mdlDue = (mdlCnt == 2); end
        else begin fire = mdlDue; mdlDue = 0; end
        mdlJam = jam; mdlLoaded = 1;
      end else begin
        mdlDue = 0;
        if (mdlLoaded) begin mdlCnt = jamValue(mdlJam, modeSel); mdlLoaded = 0; end
        if (mdlCnt == 1) begin fire = 1; mdlCnt = jamValue(jam, modeSel); end
        else mdlCnt--;
      end
      mdlOut = fire || (latchEn && mdlOut);
      mdlPrevPre = pre;
    end
  end

  always @(negedge clk) begin
    if (cmpEn) begin
      checks++;
      if (divOut !== mdlOut) begin
        fails++;
        $display("FAIL %s: divOut=%0d expected %0d at cycle %0d", curReq, divOut, mdlOut, cycleNo);
      end
    end
    if (divOut && !prevOut) begin riseCount++; riseCycle = cycleNo; end
    prevOut = divOut;
  end

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startMode(input logic [2:0] m, input logic [15:0] j, input string req);
    int t0, c0, n;
    curReq = req;
    modeSel = 3'b000; jam = j;
    tick(4);
    c0 = riseCount; t0 = cycleNo; n = jamValue(j, m);
    modeSel = m;
    wait (riseCount == c0 + 1);
    checkEq({req, " first pulse delay"}, riseCycle - t0, n);
    @(negedge clk);
  endtask

  task automatic periodCheck(input string req, input int n);
    int c0, t1;
    c0 = riseCount;
    wait (riseCount == c0 + 1);
    t1 = riseCycle;
    wait (riseCount == c0 + 2);
    checkEq({req, " period"}, riseCycle - t1, n);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    int c0, tExp;
    tick(3);
    checkEq("R8 reset low", int'(divOut), 0);
    rstN = 1'b1;
    tick(1);
    cmpEn = 1;
    checkEq("R8 after reset", int'(divOut), 0);

    // R1/R5: mode 10, N=37 and a multi-digit N=1234
    startMode(3'b111, 16'h0037, "R1");
    periodCheck("R1", 37);
    periodCheck("R5", 37);
    startMode(3'b111, 16'h1234, "R1");
    periodCheck("R1 borrow ripple", 1234);

    // R3: digit preset 12 in mode 8 -> 8*12+5=101
    startMode(3'b110, 16'h00C5, "R3");
    periodCheck("R3", 101);

    // R2: mode 2 with last section -> 2*(1000+2)+1=2005
    startMode(3'b100, 16'h0023, "R2");
    periodCheck("R2 mod2", 2005);
    // R2: mode 4 -> 4*3+2=14
    startMode(3'b101, 16'h0032, "R2");
    periodCheck("R2 mod4", 14);
    // R2: mode 5 -> 5*4+3=23
    startMode(3'b001, 16'h0043, "R2");
    periodCheck("R2 mod5", 23);
    // R1/R5 minimum: mode 4, N=3
    startMode(3'b101, 16'h0003, "R5");
    periodCheck("R5 min N", 3);

    // R4: reserved code 010 holds the counter
    startMode(3'b111, 16'h0037, "R4");
    while (mdlCnt != 20) @(negedge clk);
    modeSel = 3'b010;
    c0 = riseCount;
    tick(60);
    checkEq("R4 no pulse in hold", riseCount, c0);
    startMode(3'b111, 16'h0037, "R4");

    // R6: preset entered 2, 1 and 3 clocks before a due pulse
    curReq = "R6";
    while (mdlCnt != 2) @(negedge clk);
    c0 = riseCount; tExp = cycleNo + 2; modeSel = 3'b000;
    tick(5);
    checkEq("R6 due in 2 count", riseCount, c0 + 1);
    checkEq("R6 due in 2 time", riseCycle, tExp);
    startMode(3'b111, 16'h0037, "R6");
    while (mdlCnt != 1) @(negedge clk);
    c0 = riseCount; tExp = cycleNo + 1; modeSel = 3'b000;
    tick(5);
    checkEq("R6 due in 1 time", riseCycle, tExp);
    startMode(3'b111, 16'h0037, "R6");
    while (mdlCnt != 3) @(negedge clk);
    c0 = riseCount; modeSel = 3'b000;
    tick(5);
    checkEq("R6 dropped at 3", riseCount, c0);

    // R7: latch hold and release
    startMode(3'b111, 16'h0037, "R7");
    latchEn = 1'b1;
    c0 = riseCount;
    wait (riseCount == c0 + 1);
    tick(10);
    checkEq("R7 held high", int'(divOut), 1);
    latchEn = 1'b0;
    tick(1);
    checkEq("R7 released", int'(divOut), 0);
    tick(20);

    summary();
    $finish;
  end
endmodule